// File: doc/BRIEF.md
# Device ROM Header Validator and Entry Walker

This block takes the bytes of a device ROM image one at a time, starting at image offset 0. It first checks the fixed-size header. The 64-bit unique ID is protected by an 8-bit CRC. The header also holds a 10-bit data length, and the total image size is that length plus 13. When the header is good, the block walks the chain of length-prefixed entries that begins right after the header. For every port entry it emits a one-cycle record. Generic entries are stepped over.

Any entry that would run past the end of the image stops the walk with an error code. So does a malformed port entry. A checksum over the payload is computed outside the block and arrives on its own input. The block compares it with the header field once the walk reaches the end of the image. A `start` pulse begins each image, and `done` with `err_code` reports the final result. Fetching the bytes from memory is left to the surrounding logic.

Top module: `drom_walker_top`

## Requirements
- R1: After reset, and in the cycle after every `start` pulse, `done`, `hdr_ok`, `rev_warn` and `rec_valid` are 0 and `err_code` is 0. A `start` pulse abandons any image in progress and restarts at offset 0.
- R2: `uid` carries image bytes 1..8 in little-endian order (byte 1 in bits 7:0). `data_len` is the low 10 bits of the little-endian 16-bit field in bytes 14..15, and the upper 6 bits of that field are ignored.
- R3: A CRC-8 is run over bytes 1..8 with polynomial 0x07, start value 0xFF, MSB first and no final inversion. If the result differs from byte 0, the run ends with `err_code`=2 and `hdr_ok` stays 0.
- R4: If the total size (data length + 13) is below 22, the run ends with `err_code`=1 after byte 21. This check wins over the CRC check.
- R5: The walk starts at offset 22. Each entry is a length byte followed by a type byte: bits 5:0 give the port index, bit 6 the disabled flag, and bit 7=1 marks a port entry. Entries that are not port entries, and entries of length 1, are skipped without a record.
- R6: A port entry produces one `rec_valid` pulse, in the cycle after its last byte is accepted. For an enabled entry, `rec_link` is bit 4 of entry byte 2, `rec_has_dual` is bit 7 of entry byte 2, and `rec_partner` is bits 5:0 of entry byte 3. For a disabled entry these three fields are 0.
- R7: An entry length byte ends the run with `err_code`=3 (overrun) in three cases: it sits at offset total-1, its value is 0, or offset plus its value exceeds the total size.
- R8: A port entry that is not disabled and whose length is not 8 ends the run with `err_code`=4 once its type byte is seen.
- R9: A ROM revision (byte 13) above 1 sets `rev_warn` together with `hdr_ok` and does not stop the walk. A revision of 1 or 0 leaves `rev_warn` at 0.
- R10: When the walk reaches the total size, `data_crc_in` is compared with bytes 9..12 (little-endian). `done` rises with `err_code`=0 on a match and 5 on a mismatch.
- R11: Cycles with `byte_valid` low consume nothing. Once `done` is high, it and all results hold until the next `start`, whatever bytes arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new image at offset 0 |
| byte_valid | input | 1 | `byte_data` holds the next image byte |
| byte_data | input | 8 | Image byte |
| data_crc_in | input | 32 | Externally computed payload checksum |
| hdr_ok | output | 1 | Header passed size and ID checks |
| rev_warn | output | 1 | ROM revision above 1 |
| uid | output | 64 | Unique ID from bytes 1..8 |
| data_len | output | 10 | Payload length field |
| rec_valid | output | 1 | One-cycle port record strobe |
| rec_index | output | 6 | Port index of the record |
| rec_disabled | output | 1 | Port marked disabled |
| rec_link | output | 1 | Link number |
| rec_has_dual | output | 1 | A dual-link partner is named |
| rec_partner | output | 6 | Dual-link partner port number |
| done | output | 1 | Run finished, `err_code` final |
| err_code | output | 3 | 0 ok, 1 too small, 2 ID CRC, 3 overrun, 4 port length, 5 data checksum |

## Verification
A table of images drives the walker. One image mixes an enabled port entry, a generic entry and a disabled port entry, and ends exactly on the size boundary. This separates record emission from skipping. Further images each break one rule: a corrupted ID CRC, a size below the header, that size together with a bad CRC (to show which check wins), a zero-length entry, an entry crossing the end, a length byte in the final slot, a short enabled port entry and a wrong external checksum. Each is expected to yield its own error code and record count. Header-only images, revisions 1 and 2, a stream with idle gaps, a restart in the middle of an image and bytes sent after completion cover the remaining boundaries.

// File: rtl/drom_pkg.sv
package drom_pkg;

    localparam int DEF_LEN_W    = 10;
    localparam int HDR_BYTES    = 22;
    localparam int BASE_OFS     = 13;
    localparam int PORT_ENT_LEN = 8;
    localparam int UID_BYTES    = 8;
    localparam int DCRC_BYTES   = 4;
    localparam logic [7:0] CRC8_POLY = 8'h07;
    localparam logic [7:0] CRC8_INIT = 8'hFF;

    // header byte offsets
    localparam int OFS_IDCRC = 0;
    localparam int OFS_UID   = 1;
    localparam int OFS_DCRC  = 9;
    localparam int OFS_REV   = 13;
    localparam int OFS_LEN   = 14;

    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_SMALL    = 3'd1,
        ERR_ID_CRC   = 3'd2,
        ERR_OVERRUN  = 3'd3,
        ERR_PORT_LEN = 3'd4,
        ERR_DATA_CRC = 3'd5
    } err_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_WALK,
        PH_FIN,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic [5:0] index;
        logic       disabled;
        logic       link;
        logic       has_dual;
        logic [5:0] partner;
    } port_rec_t;

    function automatic logic [7:0] crc8_byte(input logic [7:0] acc, input logic [7:0] din);
        logic [7:0] v;
        v = acc ^ din;
        for (int k = 0; k < 8; k++) begin
            v = {v[6:0], 1'b0} ^ (v[7] ? CRC8_POLY : 8'h00);
        end
        return v;
    endfunction

endpackage

// File: rtl/drom_hdr_cap.sv
module drom_hdr_cap
    import drom_pkg::*;
#(
    parameter int LEN_W = DEF_LEN_W,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             take,
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       din,
    output logic [63:0]      uid,
    output logic [31:0]      data_crc,
    output logic [7:0]       rev,
    output logic [LEN_W-1:0] data_len,
    output logic             id_crc_ok
);

    localparam int HI_W = LEN_W - 8;

    logic [7:0]      crc_acc;
    logic [7:0]      crc_ref;
    logic [7:0]      len_lo;
    logic [HI_W-1:0] len_hi;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_acc <= CRC8_INIT;
            crc_ref <= '0;
            rev     <= '0;
            len_lo  <= '0;
            len_hi  <= '0;
        end else if (take) begin
            if (idx == IDX_W'(OFS_IDCRC)) crc_ref <= din;
            if (idx >= IDX_W'(OFS_UID) && idx < IDX_W'(OFS_UID + UID_BYTES))
                crc_acc <= crc8_byte(crc_acc, din);
            if (idx == IDX_W'(OFS_REV)) rev <= din;
            if (idx == IDX_W'(OFS_LEN)) len_lo <= din;
            if (idx == IDX_W'(OFS_LEN + 1)) len_hi <= din[HI_W-1:0];
        end
    end

    for (genvar g = 0; g < UID_BYTES; g++) begin : g_uid
        always_ff @(posedge clk) begin
            if (rst || clear) uid[8*g +: 8] <= '0;
            else if (take && idx == IDX_W'(OFS_UID + g)) uid[8*g +: 8] <= din;
        end
    end

    for (genvar g = 0; g < DCRC_BYTES; g++) begin : g_dcrc
        always_ff @(posedge clk) begin
            if (rst || clear) data_crc[8*g +: 8] <= '0;
            else if (take && idx == IDX_W'(OFS_DCRC + g)) data_crc[8*g +: 8] <= din;
        end
    end

    assign data_len  = {len_hi, len_lo};
    assign id_crc_ok = (crc_acc == crc_ref);

endmodule

// File: rtl/drom_entry_walk.sv
module drom_entry_walk
    import drom_pkg::*;
#(
    parameter int POS_W = DEF_LEN_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             take,
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] total,
    input  logic [7:0]       din,
    output logic             abort,
    output err_e             abort_code,
    output logic             rec_fire,
    output port_rec_t        rec
);

    localparam logic [POS_W:0] ONE_X = (POS_W+1)'(1);

    logic [7:0] eoff;
    logic [7:0] elen;
    logic       is_port;
    logic       dis;
    logic [5:0] pidx;
    logic       b2_link;
    logic       b2_dual;
    logic [5:0] b3_part;

    logic           first;
    logic           type_byte;
    logic [7:0]     cur_len;
    logic           last;
    logic           cur_port;
    logic           cur_dis;
    logic [5:0]     cur_idx;
    logic [POS_W:0] pos_x;
    logic [POS_W:0] tot_x;
    logic [POS_W:0] reach;

    always_comb begin
        first     = (eoff == 8'd0);
        type_byte = (eoff == 8'd1);
        cur_len   = first ? din : elen;
        last      = (eoff == cur_len - 8'd1);
        cur_port  = type_byte ? din[7]   : is_port;
        cur_dis   = type_byte ? din[6]   : dis;
        cur_idx   = type_byte ? din[5:0] : pidx;
        pos_x     = {1'b0, pos};
        tot_x     = {1'b0, total};
        reach     = pos_x + {{(POS_W-7){1'b0}}, din};

        abort      = 1'b0;
        abort_code = ERR_NONE;
        if (first) begin
            if ((pos_x + ONE_X == tot_x) || (din == 8'd0) || (reach > tot_x)) begin
                abort      = 1'b1;
                abort_code = ERR_OVERRUN;
            end
        end else if (type_byte && din[7] && !din[6] && elen != 8'(PORT_ENT_LEN)) begin
            abort      = 1'b1;
            abort_code = ERR_PORT_LEN;
        end

        rec_fire     = take && !abort && !first && last && cur_port;
        rec.index    = cur_idx;
        rec.disabled = cur_dis;
        rec.link     = cur_dis ? 1'b0 : b2_link;
        rec.has_dual = cur_dis ? 1'b0 : b2_dual;
        rec.partner  = cur_dis ? 6'd0 : b3_part;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            eoff    <= '0;
            elen    <= '0;
            is_port <= 1'b0;
            dis     <= 1'b0;
            pidx    <= '0;
            b2_link <= 1'b0;
            b2_dual <= 1'b0;
            b3_part <= '0;
        end else if (take && !abort) begin
            eoff <= last ? 8'd0 : eoff + 8'd1;
            if (first) begin
                elen    <= din;
                is_port <= 1'b0;
                dis     <= 1'b0;
                b2_link <= 1'b0;
                b2_dual <= 1'b0;
                b3_part <= '0;
            end
            if (type_byte) begin
                is_port <= din[7];
                dis     <= din[6];
                pidx    <= din[5:0];
            end
            if (eoff == 8'd2) begin
                b2_link <= din[4];
                b2_dual <= din[7];
            end
            if (eoff == 8'd3) b3_part <= din[5:0];
        end
    end

endmodule

// File: rtl/drom_walker_top.sv
module drom_walker_top
    import drom_pkg::*;
#(
    parameter int LEN_W = DEF_LEN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             byte_valid,
    input  logic [7:0]       byte_data,
    input  logic [31:0]      data_crc_in,
    output logic             hdr_ok,
    output logic             rev_warn,
    output logic [63:0]      uid,
    output logic [LEN_W-1:0] data_len,
    output logic             rec_valid,
    output logic [5:0]       rec_index,
    output logic             rec_disabled,
    output logic             rec_link,
    output logic             rec_has_dual,
    output logic [5:0]       rec_partner,
    output logic             done,
    output logic [2:0]       err_code
);

    localparam int POS_W = LEN_W + 1;
    localparam int IDX_W = $clog2(HDR_BYTES);
    localparam logic [POS_W-1:0] HDR_LAST = POS_W'(HDR_BYTES - 1);
    localparam logic [POS_W-1:0] HDR_SIZE = POS_W'(HDR_BYTES);

    phase_e          phase;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] total;
    err_e            err_q;
    port_rec_t       rec_q;

    logic        hdr_take;
    logic        walk_take;
    logic [31:0] hdr_dcrc;
    logic [7:0]  hdr_rev;
    logic        id_ok;
    logic        w_abort;
    err_e        w_code;
    logic        w_fire;
    port_rec_t   w_rec;

    assign total     = POS_W'(data_len) + POS_W'(BASE_OFS);
    assign hdr_take  = (phase == PH_HDR) && byte_valid && !start;
    assign walk_take = (phase == PH_WALK) && byte_valid && !start && (pos != total);

    drom_hdr_cap #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_hdr (
        .clk       (clk),
        .rst       (rst),
        .clear     (start),
        .take      (hdr_take),
        .idx       (pos[IDX_W-1:0]),
        .din       (byte_data),
        .uid       (uid),
        .data_crc  (hdr_dcrc),
        .rev       (hdr_rev),
        .data_len  (data_len),
        .id_crc_ok (id_ok)
    );

    drom_entry_walk #(.POS_W(POS_W)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .clear      (start),
        .take       (walk_take),
        .pos        (pos),
        .total      (total),
        .din        (byte_data),
        .abort      (w_abort),
        .abort_code (w_code),
        .rec_fire   (w_fire),
        .rec        (w_rec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            pos       <= '0;
            hdr_ok    <= 1'b0;
            rev_warn  <= 1'b0;
            done      <= 1'b0;
            err_q     <= ERR_NONE;
            rec_valid <= 1'b0;
            rec_q     <= '0;
        end else begin
            rec_valid <= 1'b0;
            if (start) begin
                phase    <= PH_HDR;
                pos      <= '0;
                hdr_ok   <= 1'b0;
                rev_warn <= 1'b0;
                done     <= 1'b0;
                err_q    <= ERR_NONE;
            end else begin
                case (phase)
                    PH_HDR: begin
                        if (byte_valid) begin
                            pos <= pos + 1'b1;
                            if (pos == HDR_LAST) begin
                                if (total < HDR_SIZE) begin
                                    err_q <= ERR_SMALL;
                                    done  <= 1'b1;
                                    phase <= PH_DONE;
                                end else if (!id_ok) begin
                                    err_q <= ERR_ID_CRC;
                                    done  <= 1'b1;
                                    phase <= PH_DONE;
                                end else begin
                                    hdr_ok   <= 1'b1;
                                    rev_warn <= (hdr_rev > 8'd1);
                                    phase    <= PH_WALK;
                                end
                            end
                        end
                    end
                    PH_WALK: begin
                        if (pos == total) begin
                            phase <= PH_FIN;
                        end else if (byte_valid) begin
                            if (w_abort) begin
                                err_q <= w_code;
                                done  <= 1'b1;
                                phase <= PH_DONE;
                            end else begin
                                pos <= pos + 1'b1;
                                if (w_fire) begin
                                    rec_valid <= 1'b1;
                                    rec_q     <= w_rec;
                                end
                            end
                        end
                    end
                    PH_FIN: begin
                        err_q <= (data_crc_in == hdr_dcrc) ? ERR_NONE : ERR_DATA_CRC;
                        done  <= 1'b1;
                        phase <= PH_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign err_code     = err_q;
    assign rec_index    = rec_q.index;
    assign rec_disabled = rec_q.disabled;
    assign rec_link     = rec_q.link;
    assign rec_has_dual = rec_q.has_dual;
    assign rec_partner  = rec_q.partner;

endmodule

// File: rtl/drom_walker_chk.sv
module drom_walker_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       hdr_ok,
    input logic       rev_warn,
    input logic       done,
    input logic [2:0] err_code,
    input logic       rec_valid,
    input logic       rec_disabled,
    input logic       rec_link,
    input logic       rec_has_dual,
    input logic [5:0] rec_partner
);

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !hdr_ok && !rev_warn && err_code == 3'd0)); // R1

    AST_HDR_FAIL_CODE: assert property (@(posedge clk) disable iff (rst)
        (done && !hdr_ok) |-> (err_code == 3'd1 || err_code == 3'd2)); // R3

    AST_REC_AFTER_HDR: assert property (@(posedge clk) disable iff (rst)
        rec_valid |-> (hdr_ok && !done)); // R5

    AST_DISABLED_REC_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (rec_valid && rec_disabled) |-> (!rec_link && !rec_has_dual && rec_partner == 6'd0)); // R6

    AST_WARN_WITH_HDR: assert property (@(posedge clk) disable iff (rst)
        rev_warn |-> hdr_ok); // R9

    AST_NO_ERR_BEFORE_DONE: assert property (@(posedge clk) disable iff (rst)
        !done |-> (err_code == 3'd0)); // R10

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(err_code) && $stable(hdr_ok))); // R11

endmodule

bind drom_walker_top drom_walker_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .hdr_ok       (hdr_ok),
    .rev_warn     (rev_warn),
    .done         (done),
    .err_code     (err_code),
    .rec_valid    (rec_valid),
    .rec_disabled (rec_disabled),
    .rec_link     (rec_link),
    .rec_has_dual (rec_has_dual),
    .rec_partner  (rec_partner)
);

// File: tb/tb_drom_walker_top.sv
`timescale 1ns/1ps
module tb_drom_walker_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic [31:0] data_crc_in;
    logic        hdr_ok;
    logic        rev_warn;
    logic [63:0] uid;
    logic [9:0]  data_len;
    logic        rec_valid;
    logic [5:0]  rec_index;
    logic        rec_disabled;
    logic        rec_link;
    logic        rec_has_dual;
    logic [5:0]  rec_partner;
    logic        done;
    logic [2:0]  err_code;

    always #4 clk = ~clk;

    drom_walker_top dut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .byte_valid   (byte_valid),
        .byte_data    (byte_data),
        .data_crc_in  (data_crc_in),
        .hdr_ok       (hdr_ok),
        .rev_warn     (rev_warn),
        .uid          (uid),
        .data_len     (data_len),
        .rec_valid    (rec_valid),
        .rec_index    (rec_index),
        .rec_disabled (rec_disabled),
        .rec_link     (rec_link),
        .rec_has_dual (rec_has_dual),
        .rec_partner  (rec_partner),
        .done         (done),
        .err_code     (err_code)
    );

    localparam logic [63:0] UID_V  = 64'h0123_4567_89AB_CDEF;
    localparam logic [31:0] DCRC_V = 32'h5A3C_81F0;

    typedef struct packed {
        logic [2:0] kind;
        logic [7:0] rev;
        logic       badc;
        logic       bade;
        logic       gaps;
        logic [2:0] eerr;
        logic       ehdr;
        logic [3:0] nrec;
        logic       ewarn;
    } vec_t;

    // kind: 0 three entries, 1 header only, 2 zero length, 3 crosses end,
    //       4 length byte in last slot, 5 short port entry, 6 size below header
    localparam vec_t VT [12] = '{
        '{3'd0, 8'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd2, 1'b0},
        '{3'd0, 8'd0, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 4'd0, 1'b0},
        '{3'd0, 8'd0, 1'b0, 1'b1, 1'b0, 3'd5, 1'b1, 4'd2, 1'b0},
        '{3'd6, 8'd0, 1'b1, 1'b0, 1'b0, 3'd1, 1'b0, 4'd0, 1'b0},
        '{3'd6, 8'd0, 1'b0, 1'b0, 1'b0, 3'd1, 1'b0, 4'd0, 1'b0},
        '{3'd2, 8'd0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 4'd0, 1'b0},
        '{3'd3, 8'd0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 4'd0, 1'b0},
        '{3'd4, 8'd0, 1'b0, 1'b0, 1'b0, 3'd3, 1'b1, 4'd0, 1'b0},
        '{3'd5, 8'd0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b1, 4'd0, 1'b0},
        '{3'd1, 8'd0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd0, 1'b0},
        '{3'd0, 8'd2, 1'b0, 1'b0, 1'b1, 3'd0, 1'b1, 4'd2, 1'b1},
        '{3'd1, 8'd1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1, 4'd0, 1'b0}
    };

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] img [0:63];
    int img_n;

    int rec_seen;
    logic [14:0] rec_log [0:15];

    always @(negedge clk) begin
        if (rst) rec_seen <= 0;
        else if (rec_valid) begin
            rec_log[rec_seen % 16] <= {rec_index, rec_disabled, rec_link, rec_has_dual, rec_partner};
            rec_seen <= rec_seen + 1;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc8(input logic [63:0] u);
        logic [7:0] v;
        v = 8'hFF;
        for (int i = 0; i < 8; i++) begin
            v = v ^ u[8*i +: 8];
            for (int k = 0; k < 8; k++) v = v[7] ? ({v[6:0], 1'b0} ^ 8'h07) : {v[6:0], 1'b0};
        end
        return v;
    endfunction

    function automatic string err_req(input logic [2:0] e);
        case (e)
            3'd1: return "R4";
            3'd2: return "R3";
            3'd3: return "R7";
            3'd4: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic build(input int kind, input logic [7:0] rev, input logic badc);
        int dlen;
        logic [9:0] dl;
        for (int i = 0; i < 64; i++) img[i] = 8'h00;
        case (kind)
            0: dlen = 22;
            1: dlen = 9;
            2, 3: dlen = 13;
            4: dlen = 10;
            5: dlen = 15;
            default: dlen = 5;
        endcase
        dl = 10'(dlen);
        img[0] = ref_crc8(UID_V) ^ {7'd0, badc};
        for (int i = 0; i < 8; i++) img[1 + i] = UID_V[8*i +: 8];
        for (int i = 0; i < 4; i++) img[9 + i] = DCRC_V[8*i +: 8];
        img[13] = rev;
        img[14] = dl[7:0];
        img[15] = {6'b101101, dl[9:8]};
        for (int i = 16; i < 22; i++) img[i] = 8'(8'h10 + i);
        case (kind)
            0: begin
                img[22] = 8'd8; img[23] = 8'h83; img[24] = 8'h92; img[25] = 8'h04;
                img[26] = 8'h5A; img[27] = 8'h5A; img[28] = 8'h5A; img[29] = 8'h5A;
                img[30] = 8'd3; img[31] = 8'h07; img[32] = 8'hEE;
                img[33] = 8'd2; img[34] = 8'hC5;
            end
            3: img[22] = 8'd5;
            4: img[22] = 8'd1;
            5: begin img[22] = 8'd6; img[23] = 8'h82; end
            default: ;
        endcase
        img_n = (dlen + 13 < 22) ? 22 : dlen + 13;
    endtask

    task automatic run_img(input logic gaps, input logic bad_ext);
        data_crc_in = bad_ext ? ~DCRC_V : DCRC_V;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < img_n; i++) begin
            byte_valid = 1'b1;
            byte_data  = img[i];
            @(negedge clk);
            if (gaps) begin
                byte_valid = 1'b0;
                byte_data  = 8'hFF;
                @(negedge clk);
            end
        end
        byte_valid = 1'b0;
        for (int w = 0; w < 40 && !done; w++) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int base;
        logic [2:0] err_hold;
        rst = 1'b1; start = 1'b0; byte_valid = 1'b0; byte_data = 8'h00; data_crc_in = '0;
        repeat (3) @(negedge clk);
        check("R1", "reset done", 64'(done), 64'd0);
        check("R1", "reset err", 64'(err_code), 64'd0);
        check("R1", "reset hdr_ok", 64'(hdr_ok), 64'd0);
        check("R1", "reset rec_valid", 64'(rec_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 12; i++) begin
            vec_t v;
            v = VT[i];
            build(int'(v.kind), v.rev, v.badc);
            base = rec_seen;
            run_img(v.gaps, v.bade);
            check(err_req(v.eerr), $sformatf("row %0d err_code", i), 64'(err_code), 64'(v.eerr));
            check("R3", $sformatf("row %0d hdr_ok", i), 64'(hdr_ok), 64'(v.ehdr));
            check("R5", $sformatf("row %0d record count", i), 64'(rec_seen - base), 64'(v.nrec));
            check("R9", $sformatf("row %0d rev_warn", i), 64'(rev_warn), 64'(v.ewarn));
            check("R11", $sformatf("row %0d done", i), 64'(done), 64'd1);
            if (i == 0) begin
                check("R2", "uid", uid, UID_V);
                check("R2", "data_len masked", 64'(data_len), 64'd22);
                check("R6", "enabled port record", 64'(rec_log[base % 16]),
                      64'({6'd3, 1'b0, 1'b1, 1'b1, 6'd4}));
                check("R6", "disabled port record", 64'(rec_log[(base + 1) % 16]),
                      64'({6'd5, 1'b1, 1'b0, 1'b0, 6'd0}));
            end
        end

        // R11: bytes after completion change nothing
        err_hold = err_code;
        base = rec_seen;
        for (int i = 0; i < 6; i++) begin
            byte_valid = 1'b1;
            byte_data  = 8'h00;
            @(negedge clk);
        end
        byte_valid = 1'b0;
        @(negedge clk);
        check("R11", "done after extra bytes", 64'(done), 64'd1);
        check("R11", "err after extra bytes", 64'(err_code), 64'(err_hold));
        check("R11", "no records after done", 64'(rec_seen - base), 64'd0);
        check("R11", "uid after extra bytes", uid, UID_V);

        // R1: restart in the middle of an image
        build(0, 8'd0, 1'b0);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R1", "done cleared by start", 64'(done), 64'd0);
        for (int i = 0; i < 12; i++) begin
            byte_valid = 1'b1;
            byte_data  = img[i];
            @(negedge clk);
        end
        byte_valid = 1'b0;
        check("R1", "partial run hdr_ok", 64'(hdr_ok), 64'd0);
        base = rec_seen;
        run_img(1'b0, 1'b0);
        check("R1", "restarted run err", 64'(err_code), 64'd0);
        check("R1", "restarted run records", 64'(rec_seen - base), 64'd2);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule